// File: doc/BRIEF.md
# SPI NOR Flash Command Sequencer

This block is the command layer of a serial NOR flash slave. An SPI shift layer hands it one received byte per transfer, flagged by a one-cycle strobe, while chip select is held low. For each accepted byte the block registers one response byte for the shift layer to send back. It decodes the first byte of a selection as an opcode. It gathers a big-endian 24-bit address, streams reads and programs against an external array engine, issues erase requests, and answers status and identification queries. It also holds the write-enable latch. Raising chip select ends the command, so the next selection starts again at an opcode.

The sequencer has six named states. **IDLE** decodes opcodes. **HDR** gathers header bytes. **RSTREAM** returns array bytes. **PSTREAM** sends bytes to the array. **REPLY** drains a short reply buffer. **HOLD** ignores everything after an erase header.

The transitions are as follows:
- IDLE to HDR on read, fast read, program and the three region erases.
- IDLE to REPLY on status and identification reads.
- HDR to RSTREAM, PSTREAM or HOLD once the last header byte has arrived.
- REPLY to IDLE after its last byte.
- Any state to IDLE whenever chip select is high.

All other opcodes leave the sequencer in IDLE. The array engine supplies read data combinationally for the address the block presents. It receives single-cycle program and erase pulses.

Top module: `spi_nor_cmd_seq`

## Requirements
- R1: After reset, and on every clock edge with `cs_n` high, `tx_byte` is 0x00 and no program or erase pulse is issued; bytes strobed while `cs_n` is high change nothing, including the write-enable latch.
- R2: Opcode 0x00 and any byte that is not one of 0x02, 0x03, 0x04, 0x05, 0x06, 0x0B, 0x20, 0x52, 0xD8, 0x9F, 0xC7 return 0x00 and leave the sequencer in IDLE, so the following byte is decoded as an opcode.
- R3: Opcode 0x03 takes three address bytes, most significant first, answering 0x00 to the opcode and to each of them; every later transfer returns the array byte at the current address and then advances it by one.
- R4: The streaming-read address is the header address modulo `ARRAY_BYTES` and steps from `ARRAY_BYTES-1` back to 0.
- R5: Opcode 0x0B takes four header bytes; the first three form the address, the fourth is ignored, and streaming then proceeds as for 0x03.
- R6: Opcode 0x02 takes three address bytes; each later byte gives one `arr_wr_en` pulse carrying that byte and the current address, and the address then increases by one.
- R7: Opcode 0x05 answers the next transfer with one byte whose bit 1 is the write-enable latch and whose other bits are zero, then returns to IDLE.
- R8: Opcode 0x06 sets the write-enable latch and 0x04 clears it; both stay in IDLE.
- R9: Opcode 0x9F answers the next three transfers with `ID_CODE` bits 23:16, 15:8, 7:0; if `ID_EXT` is nonzero, two more bytes follow, `ID_EXT` bits 15:8 and then 7:0; the sequencer then returns to IDLE.
- R10: Opcodes 0x20, 0x52 and 0xD8 take three address bytes. With the latch set, the last of them yields one `arr_erase_en` pulse with `arr_erase_kind` 0, 1 or 2 respectively and the full 24-bit address. With the latch clear, no pulse is issued. Later bytes of that selection are ignored and answered with 0x00.
- R11: Opcode 0xC7 yields one `arr_erase_en` pulse with `arr_erase_kind` 3 and address 0 on the opcode byte itself, only when the latch is set.
- R12: Raising `cs_n` in the middle of any command abandons it; the first byte of the next selection is decoded as an opcode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rx_valid | input | 1 | One-cycle strobe: `rx_byte` holds a received byte |
| rx_byte | input | 8 | Received byte |
| tx_byte | output | 8 | Registered response for the last accepted byte |
| arr_addr | output | ADDR_W | Current streaming address presented to the array |
| arr_rdata | input | 8 | Array byte at `arr_addr`, combinational |
| arr_wr_en | output | 1 | Program pulse |
| arr_wr_addr | output | ADDR_W | Program address |
| arr_wr_data | output | 8 | Program data |
| arr_erase_en | output | 1 | Erase pulse |
| arr_erase_kind | output | 2 | 0: 4 KiB, 1: 32 KiB, 2: sector, 3: whole chip |
| arr_erase_addr | output | 24 | Erase address from the header (0 for whole chip) |

## Verification
The bench goes after the header boundary. A counter that is off by one would stream one byte early, or treat the fast-read dummy byte as data, and the byte-by-byte response comparison shows the shift. A read started near the top of a small array with high address bits set catches a design that neither takes the address modulo the array size nor wraps to 0. Such a design would return bytes from the wrong location.

Identification is checked on two instances, one with an extension code and one without. A wrong reply length would either drop the extension bytes or swallow the following opcode. Erases are issued with the latch clear and with it set, and bytes are sent after an erase header. A design that ignores the latch, or that decodes those trailing bytes, would raise a stray pulse or answer a status query. Selections are also cut short in mid-header and mid-reply; a sequencer that is not reset by chip select would misread the next opcode.

// File: rtl/snc_pkg.sv
`timescale 1ns/1ps
package snc_pkg;

    localparam logic [7:0] OPC_NOP    = 8'h00;
    localparam logic [7:0] OPC_PROG   = 8'h02;
    localparam logic [7:0] OPC_READ   = 8'h03;
    localparam logic [7:0] OPC_WRDIS  = 8'h04;
    localparam logic [7:0] OPC_STAT   = 8'h05;
    localparam logic [7:0] OPC_WREN   = 8'h06;
    localparam logic [7:0] OPC_FREAD  = 8'h0B;
    localparam logic [7:0] OPC_ER4K   = 8'h20;
    localparam logic [7:0] OPC_ER32K  = 8'h52;
    localparam logic [7:0] OPC_ERSEC  = 8'hD8;
    localparam logic [7:0] OPC_IDENT  = 8'h9F;
    localparam logic [7:0] OPC_ERCHIP = 8'hC7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_RSTREAM,
        ST_PSTREAM,
        ST_REPLY,
        ST_HOLD
    } seq_state_e;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_HDR,
        ACT_WEL_SET,
        ACT_WEL_CLR,
        ACT_STATUS,
        ACT_IDENT,
        ACT_CHIP
    } act_e;

    typedef enum logic [1:0] {
        POST_READ,
        POST_PROG,
        POST_ERASE
    } post_e;

    typedef enum logic [1:0] {
        ERK_SMALL  = 2'd0,
        ERK_MID    = 2'd1,
        ERK_SECTOR = 2'd2,
        ERK_CHIP   = 2'd3
    } erase_kind_e;

    typedef struct packed {
        act_e        act;
        logic        long_hdr;
        post_e       post;
        erase_kind_e kind;
    } op_info_t;

endpackage

// File: rtl/snc_decode.sv
`timescale 1ns/1ps
module snc_decode
    import snc_pkg::*;
(
    input  logic [7:0] op,
    output op_info_t   info
);

    always_comb begin
        info = '{act: ACT_NONE, long_hdr: 1'b0, post: POST_READ, kind: ERK_SMALL};
        case (op)
            OPC_PROG:   begin info.act = ACT_HDR; info.post = POST_PROG; end
            OPC_READ:   begin info.act = ACT_HDR; info.post = POST_READ; end
            OPC_FREAD:  begin info.act = ACT_HDR; info.post = POST_READ; info.long_hdr = 1'b1; end
            OPC_ER4K:   begin info.act = ACT_HDR; info.post = POST_ERASE; info.kind = ERK_SMALL; end
            OPC_ER32K:  begin info.act = ACT_HDR; info.post = POST_ERASE; info.kind = ERK_MID; end
            OPC_ERSEC:  begin info.act = ACT_HDR; info.post = POST_ERASE; info.kind = ERK_SECTOR; end
            OPC_WREN:   info.act = ACT_WEL_SET;
            OPC_WRDIS:  info.act = ACT_WEL_CLR;
            OPC_STAT:   info.act = ACT_STATUS;
            OPC_IDENT:  info.act = ACT_IDENT;
            OPC_ERCHIP: begin info.act = ACT_CHIP; info.kind = ERK_CHIP; end
            default:    info.act = ACT_NONE;
        endcase
    end

endmodule

// File: rtl/snc_hdr_collect.sv
`timescale 1ns/1ps
module snc_hdr_collect #(
    parameter int ADDR_BYTES = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    take,
    input  logic                    long_hdr,
    input  logic [7:0]              byte_in,
    output logic                    done,
    output logic [8*ADDR_BYTES-1:0] addr
);

    localparam int MAX_HDR = ADDR_BYTES + 1;
    localparam int CNT_W   = $clog2(MAX_HDR + 1);
    localparam int AB      = 8 * ADDR_BYTES;

    logic [CNT_W-1:0] cnt_q;
    logic [AB-1:0]    sr_q;
    logic [CNT_W-1:0] last_idx;
    logic             in_addr;

    assign last_idx = long_hdr ? CNT_W'(MAX_HDR - 1) : CNT_W'(ADDR_BYTES - 1);
    assign in_addr  = cnt_q < CNT_W'(ADDR_BYTES);
    assign done     = take && (cnt_q == last_idx);
    assign addr     = in_addr ? {sr_q[AB-9:0], byte_in} : sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sr_q  <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (take) begin
            cnt_q <= cnt_q + 1'b1;
            if (in_addr) sr_q <= {sr_q[AB-9:0], byte_in};
        end
    end

endmodule

// File: rtl/snc_reply_buf.sv
`timescale 1ns/1ps
module snc_reply_buf #(
    parameter int MAX_LEN = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load,
    input  logic [LEN_W-1:0]       load_len,
    input  logic [8*MAX_LEN-1:0]   load_bytes,
    input  logic                   take,
    output logic [7:0]             cur_byte,
    output logic                   last
);

    localparam int LEN_W = $clog2(MAX_LEN + 1);

    logic [8*MAX_LEN-1:0] data_q;
    logic [LEN_W-1:0]     len_q;
    logic [LEN_W-1:0]     pos_q;

    assign cur_byte = data_q[8*pos_q +: 8];
    assign last     = (pos_q == len_q - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            len_q  <= LEN_W'(1);
            pos_q  <= '0;
        end else if (load) begin
            data_q <= load_bytes;
            len_q  <= load_len;
            pos_q  <= '0;
        end else if (take) begin
            pos_q  <= pos_q + 1'b1;
        end
    end

endmodule

// File: rtl/spi_nor_cmd_seq.sv
`timescale 1ns/1ps
module spi_nor_cmd_seq
    import snc_pkg::*;
#(
    parameter logic [23:0] ID_CODE     = 24'h1F2E3D,
    parameter logic [15:0] ID_EXT      = 16'h0000,
    parameter int          ARRAY_BYTES = 1 << 20,
    localparam int         ADDR_W      = $clog2(ARRAY_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    output logic [7:0]        tx_byte,
    output logic [ADDR_W-1:0] arr_addr,
    input  logic [7:0]        arr_rdata,
    output logic              arr_wr_en,
    output logic [ADDR_W-1:0] arr_wr_addr,
    output logic [7:0]        arr_wr_data,
    output logic              arr_erase_en,
    output logic [1:0]        arr_erase_kind,
    output logic [23:0]       arr_erase_addr
);

    localparam int              REPLY_MAX = 5;
    localparam int              LEN_W     = $clog2(REPLY_MAX + 1);
    localparam logic            HAS_EXT   = (ID_EXT != 16'h0000);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(ARRAY_BYTES - 1);

    seq_state_e  state_q, state_d;
    op_info_t    info;
    logic        accept;
    logic        wel_q;
    logic [ADDR_W-1:0] cur_q, next_addr;
    post_e       post_q;
    erase_kind_e kind_q;
    logic        long_q;
    logic [7:0]  tx_q;
    logic        wr_en_q, er_en_q;
    logic [ADDR_W-1:0] wr_addr_q;
    logic [7:0]  wr_data_q;
    erase_kind_e er_kind_q;
    logic [23:0] er_addr_q;

    logic        hdr_done;
    logic [23:0] hdr_addr;
    logic        reply_load, reply_last;
    logic [7:0]  reply_byte;
    logic [LEN_W-1:0]       reply_len;
    logic [8*REPLY_MAX-1:0] reply_bytes;

    assign accept    = rx_valid && !cs_n;
    assign next_addr = (cur_q == LAST_ADDR) ? '0 : cur_q + 1'b1;

    snc_decode u_decode (
        .op   (rx_byte),
        .info (info)
    );

    snc_hdr_collect #(.ADDR_BYTES(3)) u_hdr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (cs_n || state_q == ST_IDLE),
        .take     (accept && state_q == ST_HDR),
        .long_hdr (long_q),
        .byte_in  (rx_byte),
        .done     (hdr_done),
        .addr     (hdr_addr)
    );

    assign reply_load = accept && state_q == ST_IDLE &&
                        (info.act == ACT_STATUS || info.act == ACT_IDENT);

    always_comb begin
        if (info.act == ACT_STATUS) begin
            reply_len   = LEN_W'(1);
            reply_bytes = {32'h0, 6'b0, wel_q, 1'b0};
        end else begin
            reply_len   = HAS_EXT ? LEN_W'(5) : LEN_W'(3);
            reply_bytes = {ID_EXT[7:0], ID_EXT[15:8], ID_CODE[7:0], ID_CODE[15:8], ID_CODE[23:16]};
        end
    end

    snc_reply_buf #(.MAX_LEN(REPLY_MAX)) u_reply (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (reply_load),
        .load_len   (reply_len),
        .load_bytes (reply_bytes),
        .take       (accept && state_q == ST_REPLY),
        .cur_byte   (reply_byte),
        .last       (reply_last)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (cs_n) begin
            state_d = ST_IDLE;
        end else if (accept) begin
            unique case (state_q)
                ST_IDLE: begin
                    if (info.act == ACT_HDR)
                        state_d = ST_HDR;
                    else if (info.act == ACT_STATUS || info.act == ACT_IDENT)
                        state_d = ST_REPLY;
                end
                ST_HDR: begin
                    if (hdr_done) begin
                        unique case (post_q)
                            POST_READ:  state_d = ST_RSTREAM;
                            POST_PROG:  state_d = ST_PSTREAM;
                            default:    state_d = ST_HOLD;
                        endcase
                    end
                end
                ST_REPLY:   if (reply_last) state_d = ST_IDLE;
                ST_RSTREAM, ST_PSTREAM, ST_HOLD: state_d = state_q;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q      <= 8'h00;
            wel_q     <= 1'b0;
            cur_q     <= '0;
            post_q    <= POST_READ;
            kind_q    <= ERK_SMALL;
            long_q    <= 1'b0;
            wr_en_q   <= 1'b0;
            wr_addr_q <= '0;
            wr_data_q <= 8'h00;
            er_en_q   <= 1'b0;
            er_kind_q <= ERK_SMALL;
            er_addr_q <= '0;
        end else begin
            wr_en_q <= 1'b0;
            er_en_q <= 1'b0;
            if (cs_n) begin
                tx_q <= 8'h00;
            end else if (accept) begin
                tx_q <= 8'h00;
                unique case (state_q)
                    ST_IDLE: begin
                        post_q <= info.post;
                        kind_q <= info.kind;
                        long_q <= info.long_hdr;
                        case (info.act)
                            ACT_WEL_SET: wel_q <= 1'b1;
                            ACT_WEL_CLR: wel_q <= 1'b0;
                            ACT_CHIP: begin
                                if (wel_q) begin
                                    er_en_q   <= 1'b1;
                                    er_kind_q <= ERK_CHIP;
                                    er_addr_q <= '0;
                                end
                            end
                            default: ;
                        endcase
                    end
                    ST_HDR: begin
                        if (hdr_done) begin
                            cur_q <= hdr_addr[ADDR_W-1:0];
                            if (post_q == POST_ERASE && wel_q) begin
                                er_en_q   <= 1'b1;
                                er_kind_q <= kind_q;
                                er_addr_q <= hdr_addr;
                            end
                        end
                    end
                    ST_RSTREAM: begin
                        tx_q  <= arr_rdata;
                        cur_q <= next_addr;
                    end
                    ST_PSTREAM: begin
                        wr_en_q   <= 1'b1;
                        wr_addr_q <= cur_q;
                        wr_data_q <= rx_byte;
                        cur_q     <= next_addr;
                    end
                    ST_REPLY: tx_q <= reply_byte;
                    ST_HOLD:  ;
                    default:  ;
                endcase
            end
        end
    end

    assign tx_byte        = tx_q;
    assign arr_addr       = cur_q;
    assign arr_wr_en      = wr_en_q;
    assign arr_wr_addr    = wr_addr_q;
    assign arr_wr_data    = wr_data_q;
    assign arr_erase_en   = er_en_q;
    assign arr_erase_kind = er_kind_q;
    assign arr_erase_addr = er_addr_q;

endmodule

// File: rtl/snc_checker.sv
`timescale 1ns/1ps
module snc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       rx_valid,
    input logic [7:0] tx_byte,
    input logic       arr_wr_en,
    input logic       arr_erase_en,
    input logic       wel
);

    assert_tx_clear_deselect_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> tx_byte == 8'h00);

    assert_no_request_deselect_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (!arr_wr_en && !arr_erase_en));

    assert_request_needs_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> (!arr_wr_en && !arr_erase_en));

    assert_erase_needs_latch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        arr_erase_en |-> $past(wel));

    assert_latch_moves_on_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> $stable(wel));

    assert_single_request_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({arr_wr_en, arr_erase_en}));

endmodule

bind spi_nor_cmd_seq snc_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_n         (cs_n),
    .rx_valid     (rx_valid),
    .tx_byte      (tx_byte),
    .arr_wr_en    (arr_wr_en),
    .arr_erase_en (arr_erase_en),
    .wel          (wel_q)
);

// File: tb/spi_nor_cmd_seq_bench.sv
`timescale 1ns/1ps
module spi_nor_cmd_seq_bench;

    localparam int          SIZE = 64;
    localparam int          AW   = 6;
    localparam logic [23:0] ID   = 24'h5A3C17;
    localparam logic [15:0] EXT  = 16'hB2E4;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1;
    logic          rx_valid = 1'b0;
    logic [7:0]    rx_byte = 8'h00;
    logic [7:0]    tx_byte;
    logic [AW-1:0] arr_addr;
    logic [7:0]    arr_rdata;
    logic          arr_wr_en;
    logic [AW-1:0] arr_wr_addr;
    logic [7:0]    arr_wr_data;
    logic          arr_erase_en;
    logic [1:0]    arr_erase_kind;
    logic [23:0]   arr_erase_addr;

    logic [7:0]    n_tx;
    logic [AW-1:0] n_addr;
    logic [7:0]    n_rdata;
    logic          n_wr_en;
    logic [AW-1:0] n_wr_addr;
    logic [7:0]    n_wr_data;
    logic          n_er_en;
    logic [1:0]    n_er_kind;
    logic [23:0]   n_er_addr;

    logic [7:0] mem [SIZE];
    assign arr_rdata = mem[arr_addr];
    assign n_rdata   = mem[n_addr];

    initial begin
        for (int i = 0; i < SIZE; i++) mem[i] = 8'(i * 7 + 3);
    end
    always @(posedge clk) if (arr_wr_en) mem[arr_wr_addr] <= arr_wr_data;

    spi_nor_cmd_seq #(.ID_CODE(ID), .ID_EXT(EXT), .ARRAY_BYTES(SIZE)) u_spi_nor_cmd_seq (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tx_byte(tx_byte), .arr_addr(arr_addr), .arr_rdata(arr_rdata),
        .arr_wr_en(arr_wr_en), .arr_wr_addr(arr_wr_addr), .arr_wr_data(arr_wr_data),
        .arr_erase_en(arr_erase_en), .arr_erase_kind(arr_erase_kind), .arr_erase_addr(arr_erase_addr));

    spi_nor_cmd_seq #(.ID_CODE(ID), .ID_EXT(16'h0000), .ARRAY_BYTES(SIZE)) u_spi_nor_cmd_seq_noext (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tx_byte(n_tx), .arr_addr(n_addr), .arr_rdata(n_rdata),
        .arr_wr_en(n_wr_en), .arr_wr_addr(n_wr_addr), .arr_wr_data(n_wr_data),
        .arr_erase_en(n_er_en), .arr_erase_kind(n_er_kind), .arr_erase_addr(n_er_addr));

    // behavioural reference model
    int         checks = 0;
    int         fails  = 0;
    string      req    = "R1";
    int         mstate = 0;    // 0 idle, 1 header, 2 read, 3 program, 4 reply, 5 hold
    logic [7:0] mcmd   = 8'h00;
    bit         mwel   = 1'b0;
    int         maddr  = 0;
    logic [7:0] hq[$];
    logic [7:0] rq[$];
    logic [7:0] etx    = 8'h00;
    bit         ewr    = 1'b0;
    int         ewaddr = 0;
    logic [7:0] ewdata = 8'h00;
    bit         eer    = 1'b0;
    int         ekind  = 0;
    logic [23:0] eeaddr = '0;

    task automatic model_desel();
        mstate = 0; hq.delete(); rq.delete();
        etx = 8'h00; ewr = 1'b0; eer = 1'b0;
    endtask

    task automatic model_byte(input logic [7:0] b);
        logic [23:0] a;
        ewr = 1'b0; eer = 1'b0; etx = 8'h00;
        case (mstate)
            0: begin
                case (b)
                    8'h02, 8'h03, 8'h0B, 8'h20, 8'h52, 8'hD8: begin
                        mcmd = b; hq.delete(); mstate = 1;
                    end
                    8'h04: mwel = 1'b0;
                    8'h06: mwel = 1'b1;
                    8'h05: begin rq.delete(); rq.push_back({6'b0, mwel, 1'b0}); mstate = 4; end
                    8'h9F: begin
                        rq.delete();
                        rq.push_back(ID[23:16]); rq.push_back(ID[15:8]); rq.push_back(ID[7:0]);
                        rq.push_back(EXT[15:8]); rq.push_back(EXT[7:0]);
                        mstate = 4;
                    end
                    8'hC7: if (mwel) begin eer = 1'b1; ekind = 3; eeaddr = '0; end
                    default: ;
                endcase
            end
            1: begin
                hq.push_back(b);
                if (hq.size() == ((mcmd == 8'h0B) ? 4 : 3)) begin
                    a = {hq[0], hq[1], hq[2]};
                    maddr = int'(a) % SIZE;
                    case (mcmd)
                        8'h02: mstate = 3;
                        8'h03, 8'h0B: mstate = 2;
                        default: begin
                            mstate = 5;
                            if (mwel) begin
                                eer = 1'b1; eeaddr = a;
                                ekind = (mcmd == 8'h20) ? 0 : (mcmd == 8'h52) ? 1 : 2;
                            end
                        end
                    endcase
                end
            end
            2: begin etx = mem[maddr]; maddr = (maddr + 1) % SIZE; end
            3: begin ewr = 1'b1; ewaddr = maddr; ewdata = b; maddr = (maddr + 1) % SIZE; end
            4: begin etx = rq.pop_front(); if (rq.size() == 0) mstate = 0; end
            default: ;
        endcase
    endtask

    task automatic compare();
        bit bad = 1'b0;
        checks++;
        if (tx_byte !== etx) begin
            bad = 1'b1;
            $display("FAIL %s tx_byte actual=%02h expected=%02h", req, tx_byte, etx);
        end
        if (arr_wr_en !== ewr || (ewr && (arr_wr_addr !== AW'(ewaddr) || arr_wr_data !== ewdata))) begin
            bad = 1'b1;
            $display("FAIL %s write actual=%0b/%0d/%02h expected=%0b/%0d/%02h", req,
                     arr_wr_en, arr_wr_addr, arr_wr_data, ewr, ewaddr, ewdata);
        end
        if (arr_erase_en !== eer || (eer && (arr_erase_kind !== 2'(ekind) || arr_erase_addr !== eeaddr))) begin
            bad = 1'b1;
            $display("FAIL %s erase actual=%0b/%0d/%06h expected=%0b/%0d/%06h", req,
                     arr_erase_en, arr_erase_kind, arr_erase_addr, eer, ekind, eeaddr);
        end
        if (bad) fails++;
    endtask

    task automatic check_val(input string r, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s noext tx actual=%02h expected=%02h", r, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] b);
        @(negedge clk); rx_valid = 1'b1; rx_byte = b;
        @(posedge clk); #2;
        if (cs_n) model_desel(); else model_byte(b);
        compare();
        @(negedge clk); rx_valid = 1'b0;
        @(posedge clk); #2;
        ewr = 1'b0; eer = 1'b0;
        if (cs_n) model_desel();
        compare();
    endtask

    task automatic set_cs(input logic v);
        @(negedge clk); cs_n = v;
        @(posedge clk); #2;
        ewr = 1'b0; eer = 1'b0;
        if (v) model_desel();
        compare();
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #2;
        req = "R1"; model_desel(); compare();   // reset state

        // R1: write enable strobed while deselected has no effect
        xfer(8'h06);
        set_cs(1'b0); req = "R7"; xfer(8'h05); xfer(8'h00); set_cs(1'b1);

        // R8: latch set and clear, observed through status (R7)
        req = "R8";
        set_cs(1'b0); xfer(8'h06); xfer(8'h05); xfer(8'h00); set_cs(1'b1);
        set_cs(1'b0); xfer(8'h04); xfer(8'h05); xfer(8'h00); set_cs(1'b1);
        set_cs(1'b0); xfer(8'h06); set_cs(1'b1);

        // R2: no-op and unknown opcodes stay in idle
        req = "R2";
        set_cs(1'b0); xfer(8'h00); xfer(8'h77); xfer(8'hFF); xfer(8'h05); xfer(8'h00); set_cs(1'b1);

        // R9: identification with and without extension, then back to idle
        req = "R9";
        set_cs(1'b0);
        xfer(8'h9F); check_val("R9", n_tx, 8'h00);
        xfer(8'h00); check_val("R9", n_tx, ID[23:16]);
        xfer(8'h00); check_val("R9", n_tx, ID[15:8]);
        xfer(8'h00); check_val("R9", n_tx, ID[7:0]);
        xfer(8'h00); check_val("R9", n_tx, 8'h00);
        xfer(8'h00); check_val("R9", n_tx, 8'h00);
        xfer(8'h05); xfer(8'h00);
        set_cs(1'b1);

        // R3: plain read
        req = "R3";
        set_cs(1'b0); xfer(8'h03); xfer(8'h00); xfer(8'h00); xfer(8'h10);
        for (int i = 0; i < 4; i++) xfer(8'h00);
        set_cs(1'b1);

        // R4: modulo address and wrap to zero
        req = "R4";
        set_cs(1'b0); xfer(8'h03); xfer(8'h12); xfer(8'h34); xfer(8'h7E);
        for (int i = 0; i < 4; i++) xfer(8'h00);
        set_cs(1'b1);

        // R5: fast read with dummy byte
        req = "R5";
        set_cs(1'b0); xfer(8'h0B); xfer(8'h00); xfer(8'h00); xfer(8'h05); xfer(8'hAA);
        for (int i = 0; i < 3; i++) xfer(8'h00);
        set_cs(1'b1);

        // R6: page program then read back
        req = "R6";
        set_cs(1'b0); xfer(8'h02); xfer(8'h00); xfer(8'h00); xfer(8'h20);
        xfer(8'hA5); xfer(8'h5A); xfer(8'h3C);
        set_cs(1'b1);
        set_cs(1'b0); xfer(8'h03); xfer(8'h00); xfer(8'h00); xfer(8'h20);
        for (int i = 0; i < 3; i++) xfer(8'h00);
        set_cs(1'b1);

        // R10: region erases with latch clear, then set; trailing bytes ignored
        req = "R10";
        set_cs(1'b0); xfer(8'h04); set_cs(1'b1);
        set_cs(1'b0); xfer(8'h20); xfer(8'h01); xfer(8'h23); xfer(8'h45); set_cs(1'b1);
        set_cs(1'b0); xfer(8'h06); set_cs(1'b1);
        set_cs(1'b0); xfer(8'h20); xfer(8'h01); xfer(8'h23); xfer(8'h45);
        xfer(8'h05); xfer(8'h00); xfer(8'hC7); set_cs(1'b1);
        set_cs(1'b0); xfer(8'h52); xfer(8'hAB); xfer(8'hCD); xfer(8'hEF); set_cs(1'b1);
        set_cs(1'b0); xfer(8'hD8); xfer(8'h0F); xfer(8'h00); xfer(8'h00); set_cs(1'b1);

        // R11: whole-chip erase gated by latch
        req = "R11";
        set_cs(1'b0); xfer(8'h04); xfer(8'hC7); set_cs(1'b1);
        set_cs(1'b0); xfer(8'h06); xfer(8'hC7); set_cs(1'b1);

        // R12: abort mid-header and mid-reply
        req = "R12";
        set_cs(1'b0); xfer(8'h03); xfer(8'h00); set_cs(1'b1);
        set_cs(1'b0); xfer(8'h05); xfer(8'h00); set_cs(1'b1);
        set_cs(1'b0); xfer(8'h9F); xfer(8'h00); set_cs(1'b1);
        set_cs(1'b0); xfer(8'h05); xfer(8'h00); set_cs(1'b1);

        repeat (2) @(posedge clk);
        finish_run();
    end

endmodule